// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide, two-address register front end of a classic eight-line priority interrupt controller. It turns processor writes into controller state and into strobes for the separate priority core that holds the request and in-service registers. A write to address 0 with bit 4 set restarts the controller and opens a short initialization sequence. The following address-1 writes supply the vector base, a cascade word that is skipped, and an optional mode word. Once the sequence is complete, address-1 writes load the interrupt mask. Address-0 writes without bit 4 carry operation commands. These cover end-of-interrupt variants, priority rotation, read-register selection, special mask and poll arming.

Reads return the mask, the request register or the in-service register. In poll mode a read returns the number of the line that would be serviced, and it acknowledges that line at the same time. Read data, mode bits and strobes are all registered. A write or read presented in cycle k becomes visible on the outputs after the clock edge that ends cycle k. The clear strobes last exactly one cycle. The bus is a plain synchronous strobe with no handshake: the block always accepts in the cycle the strobe is high, so no back-pressure exists. The request, in-service and trigger-mode vectors come from the priority core as plain inputs.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset the mask, vector base, rotation base, nested, auto-EOI, rotate-on-auto-EOI and special-mask outputs are all zero. All strobes are low. The init sequence is idle, and an address-0 read returns the request vector.
- R2: An address-0 write with bit 4 set has several effects one cycle later. It clears the mask, the rotation base, the special mask and the read select. It pulses init_pulse_o, and it pulses irr_clr_o with the inverse of lvl_mode_i, which drops the edge-triggered requests. If bit 0 of that write is 0, nested and auto-EOI are cleared; if bit 0 is 1, both keep their values.
- R3: The next address-1 write after an init start stores the vector base as the data with bits 2:0 forced to zero. The address-1 write after that is discarded and leaves the mask unchanged. When no mode word was announced, the sequence then returns to normal operation.
- R4: When a mode word was announced, the third address-1 write sets nested from data bit 4 and auto-EOI from data bit 1, and then ends the sequence.
- R5: Outside the init sequence an address-1 write loads the mask. An address-0 write that is not an init start never advances the init sequence.
- R6: An address-0 write with bit 3 = 1 and bit 4 = 0 is a mode command. If bit 1 is set, bit 0 selects the read source (1 = in-service, 0 = request). If bit 6 is set, bit 5 becomes the special mask. Bit 2 arms poll mode.
- R7: An address-0 write with bits 4:3 = 00 carries the command code in bits 7:5. Codes 0 and 4 set rotate-on-auto-EOI from bit 7. Code 2 changes nothing and issues no strobe.
- R8: Code 1 pulses isr_clr_o for the highest-priority in-service line. That line is the first set bit of isr_i found by scanning upward, modulo 8, from the rotation base. Code 5 does the same and also sets the rotation base to that line plus 1. With isr_i zero, neither code has any effect.
- R9: Code 3 pulses isr_clr_o for line data[2:0]. Code 7 does the same and also sets the rotation base to data[2:0]+1 mod 8. Code 6 only sets the rotation base to data[2:0]+1 mod 8.
- R10: One cycle after a read that is not a poll, rdata_o holds the mask for address 1. For address 0 it holds isr_i or irr_i, according to the read select.
- R11: A read while poll is armed returns the poll winner in bits 2:0. The winner is the highest-ranked line of irr_i AND NOT mask, provided it outranks the highest in-service line. In the same cycle, irr_clr_o and isr_clr_o pulse the winner's one-hot bit, and poll is disarmed. With no winner the read returns 7 and issues no strobe.
- R12: isr_clr_o and irr_clr_o are single-cycle pulses, and isr_clr_o has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 1 | Register address bit |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DW | Write data |
| isr_i | input | NL | In-service vector from the priority core |
| irr_i | input | NL | Request vector from the priority core |
| lvl_mode_i | input | NL | Per-line level-trigger flags (1 = level) |
| rdata_o | output | DW | Registered read data |
| mask_o | output | NL | Interrupt mask |
| vec_base_o | output | DW | Vector base, low bits zero |
| nested_o | output | 1 | Nested mode |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask_o | output | 1 | Special mask mode |
| rot_base_o | output | LW | Line that currently has top priority |
| init_pulse_o | output | 1 | One-cycle pulse after an init start |
| irr_clr_o | output | NL | One-cycle request-clear strobe |
| isr_clr_o | output | NL | One-cycle in-service-clear strobe |

## Verification
The hardest case to reach is a poll read in which a pending request and the top in-service line sit close together in a rotated priority order. The winner flips depending on where the rotation base lies between them. To reach it, the bench moves the rotation base with random rotate commands and draws sparse random in-service and request vectors under a random mask. It then arms poll and reads. Each read's result and strobes are compared against a bench-side priority scan. A follow-up plain read proves that poll mode was left.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  typedef enum logic [1:0] {
    INIT_IDLE = 2'd0,
    INIT_BASE = 2'd1,
    INIT_CASC = 2'd2,
    INIT_MODE = 2'd3
  } init_st_e;

  typedef enum logic [2:0] {
    OP_RAEOI_CLR = 3'd0,
    OP_EOI       = 3'd1,
    OP_NOP       = 3'd2,
    OP_SPEC_EOI  = 3'd3,
    OP_RAEOI_SET = 3'd4,
    OP_ROT_EOI   = 3'd5,
    OP_SET_BASE  = 3'd6,
    OP_ROT_SPEC  = 3'd7
  } op_code_e;

  localparam int BIT_START = 4;
  localparam int BIT_MODE  = 3;
  localparam int BIT_POLL  = 2;
  localparam int BIT_RSEN  = 1;
  localparam int BIT_RSEL  = 0;
  localparam int BIT_SMEN  = 6;
  localparam int BIT_SMV   = 5;
  localparam int BIT_NEED4 = 0;
  localparam int BIT_NEST  = 4;
  localparam int BIT_AEOI  = 1;
endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
  parameter int NL = 8,
  localparam int LW = $clog2(NL),
  localparam int RW = LW + 1
) (
  input  logic [NL-1:0] vec_i,
  input  logic [LW-1:0] base_i,
  output logic          hit_o,
  output logic [LW-1:0] line_o,
  output logic [RW-1:0] rank_o
);
  logic [LW-1:0] idx;

  always_comb begin
    hit_o  = 1'b0;
    line_o = '0;
    rank_o = RW'(NL);
    idx    = '0;
    for (int k = NL - 1; k >= 0; k--) begin
      idx = base_i + LW'(k);
      if (vec_i[idx]) begin
        hit_o  = 1'b1;
        line_o = idx;
        rank_o = RW'(k);
      end
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int NL = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          start_o,
  output logic          mask_wr_o,
  output logic [DW-1:0] vec_base_o,
  output logic          nested_o,
  output logic          auto_eoi_o
);
  init_st_e st_q;
  logic     need4_q;
  logic     addr1_wr;

  assign start_o   = wr_i && !addr_i && wdata_i[BIT_START];
  assign addr1_wr  = wr_i && addr_i;
  assign mask_wr_o = addr1_wr && (st_q == INIT_IDLE);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q       <= INIT_IDLE;
      need4_q    <= 1'b0;
      vec_base_o <= '0;
      nested_o   <= 1'b0;
      auto_eoi_o <= 1'b0;
    end else if (start_o) begin
      need4_q <= wdata_i[BIT_NEED4];
      st_q    <= INIT_BASE;
      if (!wdata_i[BIT_NEED4]) begin
        nested_o   <= 1'b0;
        auto_eoi_o <= 1'b0;
      end
    end else if (addr1_wr) begin
      unique case (st_q)
        INIT_BASE: begin
          vec_base_o <= wdata_i & ~DW'(NL - 1);
          st_q       <= INIT_CASC;
        end
        INIT_CASC: st_q <= need4_q ? INIT_MODE : INIT_IDLE;
        INIT_MODE: begin
          nested_o   <= wdata_i[BIT_NEST];
          auto_eoi_o <= wdata_i[BIT_AEOI];
          st_q       <= INIT_IDLE;
        end
        default: ;
      endcase
    end
  end

  AST_START_ENTERS_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (st_q == INIT_BASE)); // R2
  AST_MODE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr1_wr && !start_o && st_q == INIT_MODE) |=>
      (nested_o == $past(wdata_i[BIT_NEST]) && st_q == INIT_IDLE)); // R4
  AST_ADDR0_NO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && !start_o) |=> $stable(st_q)); // R5
endmodule

// File: rtl/pic_op_exec.sv
module pic_op_exec
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int NL = 8,
  localparam int LW = $clog2(NL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          start_i,
  input  logic          isr_hit_i,
  input  logic [LW-1:0] isr_line_i,
  input  logic          poll_rd_i,
  output logic [NL-1:0] eoi_clr_o,
  output logic [LW-1:0] rot_base_o,
  output logic          rsel_o,
  output logic          special_mask_o,
  output logic          rot_aeoi_o,
  output logic          poll_o
);
  logic          cmd_wr, ocw2, ocw3;
  op_code_e      code;
  logic [LW-1:0] tgt;
  logic [LW-1:0] base_nx;

  assign cmd_wr = wr_i && !addr_i && !wdata_i[BIT_START];
  assign ocw3   = cmd_wr && wdata_i[BIT_MODE];
  assign ocw2   = cmd_wr && !wdata_i[BIT_MODE];
  assign code   = op_code_e'(wdata_i[DW-1:DW-3]);
  assign tgt    = wdata_i[LW-1:0];

  always_comb begin
    eoi_clr_o = '0;
    base_nx   = rot_base_o;
    if (ocw2) begin
      unique case (code)
        OP_EOI: if (isr_hit_i) eoi_clr_o[isr_line_i] = 1'b1;
        OP_ROT_EOI: if (isr_hit_i) begin
          eoi_clr_o[isr_line_i] = 1'b1;
          base_nx = isr_line_i + LW'(1);
        end
        OP_SPEC_EOI: eoi_clr_o[tgt] = 1'b1;
        OP_ROT_SPEC: begin
          eoi_clr_o[tgt] = 1'b1;
          base_nx = tgt + LW'(1);
        end
        OP_SET_BASE: base_nx = tgt + LW'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rot_base_o     <= '0;
      rsel_o         <= 1'b0;
      special_mask_o <= 1'b0;
      rot_aeoi_o     <= 1'b0;
      poll_o         <= 1'b0;
    end else begin
      if (poll_rd_i) poll_o <= 1'b0;
      if (start_i) begin
        rot_base_o     <= '0;
        rsel_o         <= 1'b0;
        special_mask_o <= 1'b0;
      end else if (ocw2) begin
        rot_base_o <= base_nx;
        if (code == OP_RAEOI_CLR || code == OP_RAEOI_SET)
          rot_aeoi_o <= wdata_i[DW-1];
      end else if (ocw3) begin
        if (wdata_i[BIT_POLL]) poll_o <= 1'b1;
        if (wdata_i[BIT_RSEN]) rsel_o <= wdata_i[BIT_RSEL];
        if (wdata_i[BIT_SMEN]) special_mask_o <= wdata_i[BIT_SMV];
      end
    end
  end

  AST_BASE_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(rot_base_o)); // R9
  AST_NOP_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocw2 && code == OP_NOP) |=> ($stable(rot_base_o) && $stable(rot_aeoi_o))); // R7
  AST_POLL_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_rd_i && !wr_i) |=> !poll_o); // R11
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int NL = 8,
  localparam int LW = $clog2(NL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NL-1:0] isr_i,
  input  logic [NL-1:0] irr_i,
  input  logic [NL-1:0] lvl_mode_i,
  output logic [DW-1:0] rdata_o,
  output logic [NL-1:0] mask_o,
  output logic [DW-1:0] vec_base_o,
  output logic          nested_o,
  output logic          auto_eoi_o,
  output logic          rot_aeoi_o,
  output logic          special_mask_o,
  output logic [LW-1:0] rot_base_o,
  output logic          init_pulse_o,
  output logic [NL-1:0] irr_clr_o,
  output logic [NL-1:0] isr_clr_o
);
  localparam int RW = LW + 1;

  logic          start, mask_wr, rsel, poll, poll_rd, poll_win;
  logic [NL-1:0] eoi_clr, pend, win_oh;
  logic          i_hit, p_hit;
  logic [LW-1:0] i_line, p_line;
  logic [RW-1:0] i_rank, p_rank;

  assign pend     = irr_i & ~mask_o;
  assign poll_rd  = rd_i && poll;
  assign poll_win = p_hit && (p_rank < i_rank);
  assign win_oh   = (poll_rd && poll_win) ? (NL'(1) << p_line) : '0;

  pic_prio_find #(.NL(NL)) u_isr_find (
    .vec_i(isr_i), .base_i(rot_base_o),
    .hit_o(i_hit), .line_o(i_line), .rank_o(i_rank)
  );

  pic_prio_find #(.NL(NL)) u_req_find (
    .vec_i(pend), .base_i(rot_base_o),
    .hit_o(p_hit), .line_o(p_line), .rank_o(p_rank)
  );

  pic_init_seq #(.DW(DW), .NL(NL)) u_init (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .start_o(start), .mask_wr_o(mask_wr),
    .vec_base_o(vec_base_o), .nested_o(nested_o), .auto_eoi_o(auto_eoi_o)
  );

  pic_op_exec #(.DW(DW), .NL(NL)) u_op (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .start_i(start), .isr_hit_i(i_hit),
    .isr_line_i(i_line), .poll_rd_i(poll_rd), .eoi_clr_o(eoi_clr),
    .rot_base_o(rot_base_o), .rsel_o(rsel),
    .special_mask_o(special_mask_o), .rot_aeoi_o(rot_aeoi_o),
    .poll_o(poll)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mask_o       <= '0;
      rdata_o      <= '0;
      init_pulse_o <= 1'b0;
      irr_clr_o    <= '0;
      isr_clr_o    <= '0;
    end else begin
      if (start)        mask_o <= '0;
      else if (mask_wr) mask_o <= wdata_i[NL-1:0];
      if (rd_i) begin
        if (poll)        rdata_o <= poll_win ? DW'(p_line) : DW'(NL - 1);
        else if (addr_i) rdata_o <= DW'(mask_o);
        else             rdata_o <= rsel ? DW'(isr_i) : DW'(irr_i);
      end
      init_pulse_o <= start;
      irr_clr_o    <= start ? ~lvl_mode_i : win_oh;
      isr_clr_o    <= eoi_clr | win_oh;
    end
  end

  AST_ISR_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(isr_clr_o)); // R12
  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (mask_o == '0 && rot_base_o == '0 && !special_mask_o && init_pulse_o)); // R2
  AST_EOI_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[DW-1:3] == 5'b00100 && isr_i == '0 && !rd_i)
      |=> (isr_clr_o == '0)); // R8
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_o)); // R5
  AST_VEC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_base_o[LW-1:0] == '0); // R3
endmodule

// File: tb/sim_pic_cmd_decoder.sv
module sim_pic_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, isr_in = '0, irr_in = '0, lvl = 8'hC3;
  logic [7:0] rdata, mask, vec, irr_clr, isr_clr;
  logic       nested, aeoi, raeoi, smm, ipulse;
  logic [2:0] rbase;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] s_isr, s_irr;
  logic       s_init;
  logic [7:0] m_mask;
  logic [2:0] m_base;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_cmd_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .isr_i(isr_in), .irr_i(irr_in), .lvl_mode_i(lvl),
    .rdata_o(rdata), .mask_o(mask), .vec_base_o(vec), .nested_o(nested),
    .auto_eoi_o(aeoi), .rot_aeoi_o(raeoi), .special_mask_o(smm),
    .rot_base_o(rbase), .init_pulse_o(ipulse), .irr_clr_o(irr_clr),
    .isr_clr_o(isr_clr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    s_isr = isr_clr; s_irr = irr_clr; s_init = ipulse;
  endtask

  task automatic do_rd(logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata; s_isr = isr_clr; s_irr = irr_clr;
  endtask

  // Bench priority scan: rank of first set bit scanning up from base, 8 if none.
  function automatic int find(logic [7:0] v, logic [2:0] b, output logic [2:0] line);
    line = 3'd0;
    for (int k = 0; k < 8; k++) begin
      logic [2:0] i;
      i = b + 3'(k);
      if (v[i]) begin line = i; return k; end
    end
    return 8;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irr_in = 8'h96; isr_in = 8'h21;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", mask, 0); chk("R1 vec", vec, 0); chk("R1 base", rbase, 0);
    chk("R1 modes", {nested, aeoi, raeoi, smm}, 0);
    chk("R1 strobes", {ipulse, isr_clr, irr_clr}, 0);
    do_rd(1'b0, d); chk("R1 read irr", d, 8'h96);

    // prepare state for init clearing
    do_wr(1'b1, 8'h5A); do_wr(1'b0, 8'hC2); do_wr(1'b0, 8'h68); do_wr(1'b0, 8'h0B);
    chk("R9 base set", rbase, 3); chk("R6 smm set", smm, 1);
    do_rd(1'b0, d); chk("R6 rsel isr", d, 8'h21);

    // Sequence A: init with mode word
    do_wr(1'b0, 8'h11);
    chk("R2 mask clr", mask, 0); chk("R2 base clr", rbase, 0); chk("R2 smm clr", smm, 0);
    chk("R2 init pulse", s_init, 1); chk("R2 irr clr edge", s_irr, 8'h3C);
    @(negedge clk);
    chk("R12 strobe gone", {ipulse, irr_clr}, 0);
    do_rd(1'b0, d); chk("R2 rsel clr", d, 8'h96);
    do_wr(1'b1, 8'h4D); chk("R3 vec", vec, 8'h48);
    do_wr(1'b1, 8'h77); chk("R3 casc skip", mask, 0); chk("R3 vec keep", vec, 8'h48);
    do_wr(1'b1, 8'h12); chk("R4 nested", nested, 1); chk("R4 aeoi", aeoi, 1);
    do_wr(1'b1, 8'h33); chk("R5 mask load", mask, 8'h33);

    // Sequence B: keep modes, addr0 writes do not advance
    do_wr(1'b0, 8'h11); chk("R2 keep modes", {nested, aeoi}, 2'b11);
    do_wr(1'b0, 8'h08);
    do_wr(1'b1, 8'hA9); chk("R5 addr0 no advance", vec, 8'hA8);
    do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h00); chk("R4 modes off", {nested, aeoi}, 0);

    // Sequence C: no mode word clears modes
    do_wr(1'b0, 8'h11); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h12);
    chk("R4 modes on", {nested, aeoi}, 2'b11);
    do_wr(1'b0, 8'h10); chk("R2 modes cleared", {nested, aeoi}, 0);
    do_wr(1'b1, 8'h27); chk("R3 vec2", vec, 8'h20);
    do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h81); chk("R3 back to normal", mask, 8'h81);
    do_rd(1'b1, d); chk("R10 read mask", d, 8'h81);

    // R6 mode command
    do_wr(1'b0, 8'h0B); do_rd(1'b0, d); chk("R6 rsel 1", d, 8'h21);
    do_wr(1'b0, 8'h09); do_rd(1'b0, d); chk("R6 rsel held", d, 8'h21);
    do_wr(1'b0, 8'h0A); do_rd(1'b0, d); chk("R10 read irr", d, 8'h96);
    do_wr(1'b0, 8'h68); chk("R6 smm on", smm, 1);
    do_wr(1'b0, 8'h28); chk("R6 smm held", smm, 1);
    do_wr(1'b0, 8'h48); chk("R6 smm off", smm, 0);

    // R7 codes 0/4/2
    isr_in = 8'hFF;
    do_wr(1'b0, 8'h80); chk("R7 raeoi set", raeoi, 1);
    do_wr(1'b0, 8'h45); chk("R7 nop strobe", s_isr, 0); chk("R7 nop raeoi", raeoi, 1);
    chk("R7 nop base", rbase, 0);
    do_wr(1'b0, 8'h00); chk("R7 raeoi clr", raeoi, 0);
    isr_in = 8'h00;
    do_wr(1'b0, 8'h20); chk("R8 empty eoi", s_isr, 0);
    do_wr(1'b0, 8'hA0); chk("R8 empty rot", rbase, 0);

    // R8/R9 random end-of-interrupt and rotation commands
    m_base = 3'd0;
    for (int n = 0; n < 300; n++) begin
      logic [2:0] cd, lo, ln;
      logic [7:0] e_clr;
      int rk;
      case ($urandom % 5)
        0: cd = 3'd1; 1: cd = 3'd3; 2: cd = 3'd5; 3: cd = 3'd6; default: cd = 3'd7;
      endcase
      lo = 3'($urandom);
      isr_in = 8'($urandom) & 8'($urandom);
      rk = find(isr_in, m_base, ln);
      e_clr = '0;
      case (cd)
        3'd1: if (rk < 8) e_clr[ln] = 1'b1;
        3'd5: if (rk < 8) begin e_clr[ln] = 1'b1; m_base = ln + 3'd1; end
        3'd3: e_clr[lo] = 1'b1;
        3'd7: begin e_clr[lo] = 1'b1; m_base = lo + 3'd1; end
        default: m_base = lo + 3'd1;
      endcase
      do_wr(1'b0, {cd, 2'b00, lo});
      if (cd == 3'd1 || cd == 3'd5) begin
        chk("R8 eoi clear", s_isr, e_clr); chk("R8 base", rbase, m_base);
      end else begin
        chk("R9 clear", s_isr, e_clr); chk("R9 base", rbase, m_base);
      end
    end

    // R11 poll reads under random mask, requests and in-service state
    for (int n = 0; n < 300; n++) begin
      logic [2:0] pl, il;
      int pr, ir;
      logic [7:0] e_oh;
      m_mask = 8'($urandom) & 8'($urandom);
      do_wr(1'b1, m_mask);
      if (n % 4 == 0) do_wr(1'b0, {3'd6, 2'b00, 3'($urandom)});
      m_base = rbase;
      if (n == 0) begin irr_in = 8'h00; isr_in = 8'h00; end
      else begin
        irr_in = 8'($urandom);
        isr_in = 8'($urandom) & 8'($urandom) & 8'($urandom);
      end
      pr = find(irr_in & ~m_mask, m_base, pl);
      ir = find(isr_in, m_base, il);
      e_oh = (pr < ir) ? (8'd1 << pl) : 8'd0;
      do_wr(1'b0, 8'h0C);
      do_rd(1'b0, d);
      chk("R11 poll data", d, (pr < ir) ? int'(pl) : 7);
      chk("R11 poll irr clr", s_irr, e_oh);
      chk("R11 poll isr clr", s_isr, e_oh);
      do_rd(1'b0, d);
      chk("R11 poll exit", d, irr_in);
      chk("R12 no strobe", s_isr | s_irr, 0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule